// File: doc/BRIEF.md
# Indirect ROM Lookup Sequencer

This block holds the 11-bit program counter and the three-deep return stack of a small 4-bit controller core. It also sequences the two instructions that use program memory as data: a table lookup that loads an 8-bit result register, and an indirect jump. Both instructions address the ROM with a word built from the upper three bits of the already-advanced PC, the 4-bit accumulator and the 4-bit RAM operand. The ROM is a synchronous read port. Its data returns one clock after the address is presented, so an executed indirect instruction takes two instruction cycles. A skipped indirect instruction takes one cycle.

The table lookup uses the return stack as scratch. It first pushes the return address and moves the PC to the table entry. It then pops, so sequential execution resumes and the entry that was deepest on the stack is lost. Plain calls and returns use the same stack. Decode, the ALU and the ROM array itself are outside this block.

Top module: `lookup_seq`

## Requirements
- R1: While reset is asserted and directly after it is released, `pc`, `stk_a`, `stk_b`, `stk_c` and `qreg` are all zero and `busy` is low.
- R2: Opcodes are `op` = 0 step, 1 lookup, 2 indirect jump, 3 call, 4 return, and 5 to 7 behave as step. An executed step advances `pc` by one modulo 2048 and crosses 64-word and 256-word boundaries freely. Whenever no indirect access is in progress, `rom_addr` equals `pc`.
- R3: In the strobe cycle of an executed lookup or jump, `rom_addr` is {(pc+1)[10:8], `acc`, `mem`}. An instruction at address xFF therefore addresses the following 256-word group.
- R4: In the cycle after an executed lookup strobe, `busy` is high. The stack has been pushed (`stk_a` = old pc+1, `stk_b` = old `stk_a`, `stk_c` = old `stk_b`) and `pc` holds the lookup address.
- R5: At the end of a lookup, `qreg` holds the ROM word at the lookup address and the stack has been popped. As a result, `pc` = old pc+1, `stk_a` and `stk_b` are back at their old values, and `stk_c` holds the old `stk_b`.
- R6: An executed indirect jump raises `busy` for exactly one cycle. Afterwards `pc` = {(old pc+1)[10:8], ROM word at the jump address}, and the stack is unchanged.
- R7: With `skip` high at the strobe, any opcode only advances `pc` by one. `busy` stays low, and `qreg` and the stack are unchanged.
- R8: An executed call pushes old pc+1 onto the stack, moving `stk_a` to `stk_b` and `stk_b` to `stk_c`, and loads `pc` with {(pc+1)[10:8], `acc`, `mem`}.
- R9: An executed return loads `pc` from `stk_a`, moves `stk_b` to `stk_a` and `stk_c` to `stk_b`, and leaves `stk_c` as it was.
- R10: `qreg` changes only at the end of the second cycle of an executed lookup.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one instruction cycle per edge |
| rst_n | input | 1 | Active-low synchronous reset |
| strobe | input | 1 | A new instruction is issued this cycle |
| op | input | 3 | Instruction select (see R2) |
| skip | input | 1 | The issued instruction is skipped |
| acc | input | 4 | Accumulator value |
| mem | input | 4 | RAM word addressed by the data pointer |
| rom_data | input | 8 | ROM word, one cycle after `rom_addr` |
| rom_addr | output | 11 | ROM read address |
| pc | output | 11 | Program counter |
| stk_a | output | 11 | Top stack level |
| stk_b | output | 11 | Middle stack level |
| stk_c | output | 11 | Deepest stack level |
| qreg | output | 8 | Lookup result register |
| busy | output | 1 | Second cycle of an executed indirect instruction |

## Verification
The assertions take two things for granted about the inputs. `strobe` is never raised while `busy` is high. `rom_data` is the word at the address presented on the previous edge. The bench meets both conditions. Each instruction is issued for one cycle, and the bench waits until the indirect second cycle is over before issuing the next. The ROM model is a registered function of `rom_addr`. The stimulus combines directed boundary runs at address xFF in every group, including the wrap from 7FF to 000, with a long pseudo-random mix of all opcodes and skips. Each instruction is compared against an arithmetic model of the PC and the stack.

// File: rtl/lookup_seq.sv
module lookup_seq #(
  parameter int PCW = 11,
  parameter int NW  = 4,
  parameter int DW  = 8,
  parameter int OPW = 3
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           strobe,
  input  logic [OPW-1:0] op,
  input  logic           skip,
  input  logic [NW-1:0]  acc,
  input  logic [NW-1:0]  mem,
  input  logic [DW-1:0]  rom_data,
  output logic [PCW-1:0] rom_addr,
  output logic [PCW-1:0] pc,
  output logic [PCW-1:0] stk_a,
  output logic [PCW-1:0] stk_b,
  output logic [PCW-1:0] stk_c,
  output logic [DW-1:0]  qreg,
  output logic           busy
);
  localparam int LOW = 2 * NW;
  localparam logic [OPW-1:0] OP_LKP  = OPW'(1);
  localparam logic [OPW-1:0] OP_JMP  = OPW'(2);
  localparam logic [OPW-1:0] OP_CALL = OPW'(3);
  localparam logic [OPW-1:0] OP_RET  = OPW'(4);

  logic [PCW-1:0] pc_r, sa_r, sb_r, sc_r;
  logic [DW-1:0]  q_r;
  logic           busy_r, lkp_r;

  logic [PCW-1:0] pc_inc, ind_addr;
  logic           issue, ind_go;

  assign pc_inc   = pc_r + PCW'(1);
  assign ind_addr = {pc_inc[PCW-1:LOW], acc, mem};
  assign issue    = strobe && !busy_r;
  assign ind_go   = issue && !skip && (op == OP_LKP || op == OP_JMP);
  assign rom_addr = ind_go ? ind_addr : pc_r;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pc_r   <= '0;
      sa_r   <= '0;
      sb_r   <= '0;
      sc_r   <= '0;
      q_r    <= '0;
      busy_r <= 1'b0;
      lkp_r  <= 1'b0;
    end else if (busy_r) begin
      busy_r <= 1'b0;
      if (lkp_r) begin
        q_r  <= rom_data;
        pc_r <= sa_r;
        sa_r <= sb_r;
        sb_r <= sc_r;
      end else begin
        pc_r[LOW-1:0] <= rom_data[LOW-1:0];
      end
    end else if (issue) begin
      if (skip) begin
        pc_r <= pc_inc;
      end else begin
        unique case (op)
          OP_LKP: begin
            pc_r   <= ind_addr;
            sa_r   <= pc_inc;
            sb_r   <= sa_r;
            sc_r   <= sb_r;
            busy_r <= 1'b1;
            lkp_r  <= 1'b1;
          end
          OP_JMP: begin
            pc_r   <= pc_inc;
            busy_r <= 1'b1;
            lkp_r  <= 1'b0;
          end
          OP_CALL: begin
            pc_r <= ind_addr;
            sa_r <= pc_inc;
            sb_r <= sa_r;
            sc_r <= sb_r;
          end
          OP_RET: begin
            pc_r <= sa_r;
            sa_r <= sb_r;
            sb_r <= sc_r;
          end
          default: pc_r <= pc_inc;
        endcase
      end
    end
  end

  assign pc    = pc_r;
  assign stk_a = sa_r;
  assign stk_b = sb_r;
  assign stk_c = sc_r;
  assign qreg  = q_r;
  assign busy  = busy_r;

  // R6
  busy_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy_r |=> !busy_r);

  // R10
  q_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(busy_r && lkp_r) |=> q_r == $past(q_r));

  // R5
  lkp_restore_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_r && lkp_r) |=> (pc_r == $past(pc_r, 2) + PCW'(1)) && (sa_r == $past(sa_r, 2)));

  // R6
  jmp_upper_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_r && !lkp_r) |=> (pc_r[PCW-1:LOW] == $past(pc_r[PCW-1:LOW])) && $stable(sa_r) && $stable(sc_r));

  // R7
  skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe && !busy_r && skip) |=> !busy_r && (pc_r == $past(pc_r) + PCW'(1)) && $stable(sb_r) && $stable(q_r));
endmodule

// File: tb/tb_lookup_seq.sv
module tb_lookup_seq;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        strobe = 1'b0;
  logic [2:0]  op = '0;
  logic        skip = 1'b0;
  logic [3:0]  acc = '0, mem = '0;
  logic [7:0]  rom_q = '0;
  logic [10:0] rom_addr, pc, stk_a, stk_b, stk_c;
  logic [7:0]  qreg;
  logic        busy;

  int checks = 0, fails = 0;
  bit done = 1'b0;
  logic [10:0] m_pc = '0, m_sa = '0, m_sb = '0, m_sc = '0;
  logic [7:0]  m_q = '0;
  logic [31:0] rng = 32'h1234_5678;

  always #2 clk = ~clk;

  lookup_seq dut (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .op(op), .skip(skip),
    .acc(acc), .mem(mem), .rom_data(rom_q), .rom_addr(rom_addr), .pc(pc),
    .stk_a(stk_a), .stk_b(stk_b), .stk_c(stk_c), .qreg(qreg), .busy(busy)
  );

  function automatic logic [7:0] romf(input logic [10:0] a);
    return a[7:0] ^ {a[10:8], a[10:8], 2'b01};
  endfunction

  always_ff @(posedge clk) rom_q <= romf(rom_addr);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    end
  endtask

  task automatic run(input logic [2:0] o, input bit sk, input logic [3:0] a, input logic [3:0] m);
    logic [10:0] pcn, ad;
    bit ind;
    string t;
    pcn = m_pc + 11'd1;
    ad  = {pcn[10:8], a, m};
    ind = !sk && (o == 3'd1 || o == 3'd2);
    @(negedge clk);
    strobe = 1'b1; op = o; skip = sk; acc = a; mem = m;
    #1;
    if (ind) chk("R3 indirect address", rom_addr, ad);
    else     chk("R2 fetch address", rom_addr, m_pc);
    @(negedge clk);
    strobe = 1'b0;
    if (ind) begin
      if (o == 3'd1) begin
        chk("R4 busy", busy, 1);
        chk("R4 pc", pc, ad);
        chk("R4 stk_a", stk_a, pcn);
        chk("R4 stk_b", stk_b, m_sa);
        chk("R4 stk_c", stk_c, m_sb);
        chk("R10 q early", qreg, m_q);
      end else begin
        chk("R6 busy", busy, 1);
        chk("R6 pc mid", pc, pcn);
      end
      #1;
      chk("R2 idle fetch address", rom_addr, pc);
      @(negedge clk);
      if (o == 3'd1) begin
        m_q = romf(ad); m_sc = m_sb; m_pc = pcn;
      end else begin
        m_pc = {pcn[10:8], romf(ad)};
      end
    end else if (sk) begin
      m_pc = pcn;
    end else begin
      case (o)
        3'd3: begin m_sc = m_sb; m_sb = m_sa; m_sa = pcn; m_pc = ad; end
        3'd4: begin m_pc = m_sa; m_sa = m_sb; m_sb = m_sc; end
        default: m_pc = pcn;
      endcase
    end
    t = sk ? "R7" : (o == 3'd1) ? "R5" : (o == 3'd2) ? "R6" :
        (o == 3'd3) ? "R8" : (o == 3'd4) ? "R9" : "R2";
    chk({t, " pc"}, pc, m_pc);
    chk({t, " stk_a"}, stk_a, m_sa);
    chk({t, " stk_b"}, stk_b, m_sb);
    chk({t, " stk_c"}, stk_c, m_sc);
    chk({t, " busy low"}, busy, 0);
    chk("R10 qreg", qreg, m_q);
  endtask

  task automatic goto_low(input logic [7:0] l);
    logic [10:0] pcn;
    logic [7:0] v;
    pcn = m_pc + 11'd1;
    v = l ^ {pcn[10:8], pcn[10:8], 2'b01};
    run(3'd2, 1'b0, v[7:4], v[3:0]);
  endtask

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog expired actual=running expected=finished");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 pc in reset", pc, 0);
    chk("R1 busy in reset", busy, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 pc", pc, 0);
    chk("R1 stk_a", stk_a, 0);
    chk("R1 stk_b", stk_b, 0);
    chk("R1 stk_c", stk_c, 0);
    chk("R1 qreg", qreg, 0);
    chk("R1 busy", busy, 0);

    for (int i = 0; i < 3; i++) run(3'd0, 1'b0, 4'd0, 4'd0);

    run(3'd3, 1'b0, 4'h3, 4'h1);
    run(3'd3, 1'b0, 4'h5, 4'h2);
    run(3'd3, 1'b0, 4'h7, 4'h4);
    run(3'd1, 1'b0, 4'hA, 4'hB);
    run(3'd1, 1'b1, 4'hC, 4'hD);
    run(3'd2, 1'b1, 4'h1, 4'h2);
    run(3'd4, 1'b0, 4'h0, 4'h0);
    run(3'd4, 1'b0, 4'h0, 4'h0);

    for (int g = 0; g < 9; g++) begin
      goto_low(8'hFE);
      run(3'd0, 1'b0, 4'd0, 4'd0);
      run(3'd1, 1'b0, 4'(g), 4'(15 - g));
      goto_low(8'hFE);
      run(3'd0, 1'b0, 4'd0, 4'd0);
      run(3'd2, 1'b0, 4'(g + 3), 4'(g));
      run(3'd3, 1'b0, 4'hF, 4'hF);
      run(3'd1, 1'b0, 4'(g), 4'(g));
      for (int k = 0; k < 300; k++) run(3'd0, 1'b0, 4'd0, 4'd0);
    end

    for (int i = 0; i < 4000; i++) begin
      logic [2:0] o;
      rng = rng ^ (rng << 13);
      rng = rng ^ (rng >> 17);
      rng = rng ^ (rng << 5);
      o = 3'(rng[2:0] % 6);
      if (o == 3'd5) o = 3'd0;
      run(o, rng[5:4] == 2'b00, rng[11:8], rng[15:12]);
    end

    summary();
    $finish;
  end
endmodule